// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

This block adds two 16-bit unsigned operands and a carry-in, producing a 16-bit sum and a carry-out, entirely in combinational logic. The operand width is cut into four 4-bit groups. Each group forms per-bit generate (both operand bits set) and propagate (either operand bit set) signals. It resolves its internal carries as flat sums of products, and it summarises itself as one group-generate and one group-propagate term.

A second lookahead level takes the four group summaries and the carry-in, and forms the carry into every group at the same time as flat sums of products. No carry passes from one group to the next. The sum bits of each group are the XOR of the two operand bits and the carry into that bit position.

Instantiate it wherever a single-cycle add with short carry depth is needed. There is no clock, reset or handshake. The outputs follow the inputs after the logic settles.

Top module: `cla16_adder`

## Requirements
- R1: `sumOut` equals the low 16 bits of `opA + opB + carryIn`, treating both operands as unsigned.
- R2: `carryOut` equals bit 16 of the 17-bit result `opA + opB + carryIn`, so it is 1 exactly when that total exceeds 0xFFFF.
- R3: When a 4-bit group of the operands sums to more than 0xF by itself, the carry into the next higher group is 1 whatever the group's own carry-in is.
- R4: When a 4-bit group has a bit position with both operand bits 0 and does not generate, the carry into the next group is 0 even if that group's carry-in is 1.
- R5: When every bit position of a group has exactly one operand bit set, the group passes its carry-in unchanged to the next group, including across all four groups (0xFFFF + 0x0000 + 1 gives sum 0x0000, carry-out 1).
- R6: The carry into groups 1 to 3 and the final carry-out come from the second lookahead level and agree with the carry-out that each lower group's own lookahead would produce.
- R7: The block holds no state; a change on any input is reflected on `sumOut` and `carryOut` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First unsigned operand |
| opB | input | 16 | Second unsigned operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 16 | Low 16 bits of the total |
| carryOut | output | 1 | Carry out of bit 15 |

## Verification
The bound checker tests every input change against the full 17-bit total. It also tests how each group's summary relates to the carry handed to the group above. The summary either forces that carry to 1, forces it to 0, or passes the incoming carry through. The checker also confirms that the second level agrees with each group's own carry-out. Long propagate chains crossing several groups can only be shown by the bench scenarios, such as 0x7FFF + 0x0001 and 0xAAAA + 0x5555 + 1. So can the settling of the outputs with no clock edge, and broad random coverage.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int DEF_WIDTH   = 16;
  localparam int DEF_GROUP_W = 4;

  // Per-bit signals handed from the bit stage to a group
  typedef struct packed {
    logic gen;
    logic prop;
  } bitPg_t;
endpackage

// File: rtl/cla_pg_bits.sv
module cla_pg_bits
  import cla_pkg::*;
#(
  parameter int W = DEF_GROUP_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output bitPg_t       pg [W]
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign pg[i].gen  = a[i] & b[i];
    assign pg[i].prop = a[i] | b[i];
  end
endmodule

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
#(
  parameter int W = DEF_GROUP_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         grpGen,
  output logic         grpProp,
  output logic         cout
);
  bitPg_t       pg [W];
  logic [W:0]   bitCarry;
  logic [W-1:0] g;
  logic [W-1:0] p;

  cla_pg_bits #(.W(W)) pg_i (.a(a), .b(b), .pg(pg));

  for (genvar i = 0; i < W; i++) begin : g_unpack
    assign g[i] = pg[i].gen;
    assign p[i] = pg[i].prop;
  end

  // Each carry is a flat OR of product terms; no chained carry
  always_comb begin
    logic acc;
    logic run;
    bitCarry[0] = cin;
    for (int k = 1; k <= W; k++) begin
      run = cin;
      for (int j = 0; j < k; j++) run = run & p[j];
      acc = run;
      for (int j = 0; j < k; j++) begin
        run = g[j];
        for (int m = j + 1; m < k; m++) run = run & p[m];
        acc = acc | run;
      end
      bitCarry[k] = acc;
    end
  end

  // Group summary terms, independent of cin
  always_comb begin
    logic acc;
    logic run;
    acc = 1'b0;
    for (int j = 0; j < W; j++) begin
      run = g[j];
      for (int m = j + 1; m < W; m++) run = run & p[m];
      acc = acc | run;
    end
    grpGen  = acc;
    grpProp = &p;
  end

  assign sum  = a ^ b ^ bitCarry[W-1:0];
  assign cout = bitCarry[W];
endmodule

// File: rtl/cla_carry_unit.sv
module cla_carry_unit #(
  parameter int NG = 4
) (
  input  logic [NG-1:0] grpGen,
  input  logic [NG-1:0] grpProp,
  input  logic          cin,
  output logic [NG:0]   grpCarry
);
  // Second level: carry into every group computed in parallel
  always_comb begin
    logic acc;
    logic run;
    grpCarry[0] = cin;
    for (int k = 1; k <= NG; k++) begin
      run = cin;
      for (int j = 0; j < k; j++) run = run & grpProp[j];
      acc = run;
      for (int j = 0; j < k; j++) begin
        run = grpGen[j];
        for (int m = j + 1; m < k; m++) run = run & grpProp[m];
        acc = acc | run;
      end
      grpCarry[k] = acc;
    end
  end
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
  import cla_pkg::*;
#(
  parameter int WIDTH   = DEF_WIDTH,
  parameter int GROUP_W = DEF_GROUP_W
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  localparam int NUM_GROUPS = WIDTH / GROUP_W;

  logic [NUM_GROUPS-1:0] grpGen;
  logic [NUM_GROUPS-1:0] grpProp;
  logic [NUM_GROUPS-1:0] grpCout;
  logic [NUM_GROUPS:0]   grpCarry;

  for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
    cla_group #(.W(GROUP_W)) grp_i (
      .a      (opA[k*GROUP_W +: GROUP_W]),
      .b      (opB[k*GROUP_W +: GROUP_W]),
      .cin    (grpCarry[k]),
      .sum    (sumOut[k*GROUP_W +: GROUP_W]),
      .grpGen (grpGen[k]),
      .grpProp(grpProp[k]),
      .cout   (grpCout[k])
    );
  end

  cla_carry_unit #(.NG(NUM_GROUPS)) carry_i (
    .grpGen  (grpGen),
    .grpProp (grpProp),
    .cin     (carryIn),
    .grpCarry(grpCarry)
  );

  assign carryOut = grpCarry[NUM_GROUPS];
endmodule

// File: rtl/cla16_adder_chk.sv
module cla16_adder_chk #(
  parameter int WIDTH   = 16,
  parameter int GROUP_W = 4
) (
  input logic [WIDTH-1:0]         opA,
  input logic [WIDTH-1:0]         opB,
  input logic                     carryIn,
  input logic [WIDTH-1:0]         sumOut,
  input logic                     carryOut,
  input logic [WIDTH/GROUP_W-1:0] grpGen,
  input logic [WIDTH/GROUP_W-1:0] grpProp,
  input logic [WIDTH/GROUP_W-1:0] grpCout,
  input logic [WIDTH/GROUP_W:0]   grpCarry
);
  localparam int NG = WIDTH / GROUP_W;

  logic [WIDTH:0] refTotal;
  assign refTotal = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    // R1 R2
    sum_match_chk: assert ({carryOut, sumOut} == refTotal)
      else $error("sum_match_chk");
    for (int k = 0; k < NG; k++) begin
      // R6
      carry_agree_chk: assert (grpCarry[k+1] == grpCout[k])
        else $error("carry_agree_chk group %0d", k);
      // R3
      gen_force_chk: assert (!grpGen[k] || grpCarry[k+1])
        else $error("gen_force_chk group %0d", k);
      // R4
      kill_chk: assert (grpGen[k] || grpProp[k] || !grpCarry[k+1])
        else $error("kill_chk group %0d", k);
      // R5
      pass_chk: assert (grpGen[k] || !grpProp[k] || (grpCarry[k+1] == grpCarry[k]))
        else $error("pass_chk group %0d", k);
    end
  end
endmodule

bind cla16_adder cla16_adder_chk #(.WIDTH(WIDTH), .GROUP_W(GROUP_W)) chk_i (
  .opA(opA), .opB(opB), .carryIn(carryIn), .sumOut(sumOut), .carryOut(carryOut),
  .grpGen(grpGen), .grpProp(grpProp), .grpCout(grpCout), .grpCarry(grpCarry)
);

// File: tb/cla16_adder_tb_top.sv
`timescale 1ns/1ps
module cla16_adder_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [15:0] sumOut;
  logic        carryOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  cla16_adder dut_i (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sumOut(sumOut), .carryOut(carryOut)
  );

  // {carryIn, opA, opB, expected carry, expected sum}
  localparam int NV = 12;
  localparam logic [49:0] VECS [NV] = '{
    {1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000},
    {1'b0, 16'h7FFF, 16'h0001, 1'b0, 16'h8000},  // long propagate
    {1'b1, 16'hFFFF, 16'h0000, 1'b1, 16'h0000},  // R5 chain
    {1'b0, 16'hFFFF, 16'h0001, 1'b1, 16'h0000},
    {1'b0, 16'h000F, 16'h0001, 1'b0, 16'h0010},  // R3
    {1'b1, 16'h000F, 16'h0001, 1'b0, 16'h0011},  // R3
    {1'b0, 16'h0F0F, 16'h0101, 1'b0, 16'h1010},
    {1'b0, 16'h8000, 16'h8000, 1'b1, 16'h0000},  // R2
    {1'b1, 16'h1234, 16'h4321, 1'b0, 16'h5556},
    {1'b1, 16'h00F0, 16'h0000, 1'b0, 16'h00F1},  // R4
    {1'b1, 16'hAAAA, 16'h5555, 1'b1, 16'h0000},  // R5
    {1'b1, 16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF}
  };

  task automatic check(input string tag, input logic [16:0] exp);
    nChecks++;
    if ({carryOut, sumOut} !== exp) begin
      nFails++;
      $display("FAIL %s: a=%h b=%h cin=%b actual=%h expected=%h",
               tag, opA, opB, carryIn, {carryOut, sumOut}, exp);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
    @(negedge clk);
    opA = a; opB = b; carryIn = c;
    #1;
  endtask

  function automatic logic [16:0] refAdd(input logic [15:0] a, input logic [15:0] b,
                                         input logic c);
    return {1'b0, a} + {1'b0, b} + {16'd0, c};
  endfunction

  initial begin
    // Idle state: zero inputs give zero outputs
    apply(16'h0000, 16'h0000, 1'b0);
    check("R1 idle", 17'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i][48:33], VECS[i][32:17], VECS[i][49]);
      check("R1/R2 table", VECS[i][16:0]);
    end

    // R3: group 1 generates, carry into group 2 set for either cin
    apply(16'h0080, 16'h0080, 1'b0); check("R3 gen cin0", 17'h00100);
    apply(16'h0080, 16'h0080, 1'b1); check("R3 gen cin1", 17'h00101);
    // R4: group 0 kills an incoming carry, group 1 untouched
    apply(16'h0F00, 16'h00F0, 1'b1); check("R4 kill", 17'h00FF1);
    // R5: carry passes through groups 1 and 2 into group 3
    apply(16'h0FFF, 16'h0001, 1'b0); check("R5 pass", 17'h01000);
    // R6: second-level carry into each group and out
    apply(16'hF0F0, 16'h1010, 1'b0); check("R6 group carries", 17'h10100);
    apply(16'h0FF8, 16'h0008, 1'b0); check("R6 ripple groups", 17'h01000);
    // R2: carry-out boundary
    apply(16'hFFFE, 16'h0001, 1'b0); check("R2 no carry", 17'h0FFFF);
    apply(16'hFFFE, 16'h0001, 1'b1); check("R2 carry", 17'h10000);

    // R7: output follows input without any clock edge
    @(posedge clk); #1;
    opA = 16'h1111; opB = 16'h2222; carryIn = 1'b0;
    #1; check("R7 no clock", 17'h03333);
    opA = 16'hFFFF;
    #1; check("R7 no clock", 17'h12221);

    // Random against behavioural add (R1 R2)
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] ra;
      logic [15:0] rb;
      logic        rc;
      ra = 16'($urandom);
      rb = 16'($urandom);
      rc = 1'($urandom);
      apply(ra, rb, rc);
      check("R1/R2 random", refAdd(ra, rb, rc));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule